// File: doc/BRIEF.md
# Parallel Port Status and Control Register Unit

This unit sits on the host side of a printer-style parallel port. It gives a CPU register bus two registers. A status byte is assembled from the printer handshake pins and a sticky timeout flag for enhanced-parallel (EPP) bus cycles. A control register holds six writable bits. The printer pins are asynchronous, so they pass through a two-stage synchroniser before they reach the read path. A status or control read returns a value that is taken when the read strobe first goes high, and the unit holds that value until the strobe drops.

The timeout flag sets when an EPP strobe has stayed asserted, with no wait handshake from the peripheral, for ten microseconds. The unit counts this time in clock cycles derived from a clock-frequency parameter. A run-time select input chooses how software clears the flag. With the select low, software writes a one to bit 0. With the select high, the flag clears when a status read finishes. If a new timeout and a clear fall in the same cycle, the timeout wins.

Top module: `prn_status_regs`

## Requirements
- R1: The status register is at offset 1 and the control register at offset 2. A read of any other offset returns 0x00, and `rdData` is 0x00 whenever `rdStb` is low.
- R2: Status bits 3, 4, 5 and 6 return the synchronised levels of `errN`, `sel`, `paperEnd` and `ackN` without inversion. Bit 7 returns the inverse of `busy`. A pin change shows in reads starting three or more cycles later.
- R3: Status bits 1 and 2 always read 0.
- R4: For the whole read cycle (`rdStb` held high), `rdData` keeps the value present in the cycle where `rdStb` rose, even if pins or the flag change.
- R5: Status bit 0 sets on the TO_CYCLES-th consecutive clock edge at which `eppEn` and `eppStrobe` are high and `eppWait` is low, where TO_CYCLES = (CLK_HZ/1e6)*TIMEOUT_US. A shorter run does not set it, and nothing sets it while `eppEn` is low.
- R6: With `toModeSel` = 0, writing a byte with bit 0 = 1 to offset 1 clears the flag. Writing bit 0 = 0 leaves the flag unchanged, and status reads do not clear it.
- R7: With `toModeSel` = 1, the flag clears in the cycle after `rdStb` falls at the end of a status read, so that read still returns it set. Writes to offset 1 do not clear it.
- R8: When a timeout and a clear happen on the same clock edge, the flag ends up set.
- R9: Control bits 5:0 are written from `wrData[5:0]` by a write to offset 2 and read back unchanged. Bits 7:6 always read 0.
- R10: Reset clears the timeout flag and control bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register offset |
| rdStb | input | 1 | Read cycle strobe, high for the whole read |
| wrStb | input | 1 | One-cycle write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data |
| errN | input | 1 | Printer error pin, low = error |
| sel | input | 1 | Printer selected pin |
| paperEnd | input | 1 | Paper end pin |
| ackN | input | 1 | Acknowledge pin, low = accepted |
| busy | input | 1 | Printer busy pin |
| toModeSel | input | 1 | Flag clear policy: 0 write-one, 1 clear after status read |
| eppEn | input | 1 | EPP mode enable |
| eppStrobe | input | 1 | EPP bus cycle strobe in progress |
| eppWait | input | 1 | Peripheral wait handshake |

## Verification
The bench builds the unit with CLK_HZ = 2 MHz and TIMEOUT_US = 10, which gives a 20-cycle timeout. With that setting the run one cycle short of the limit, the run that reaches it exactly, and a timeout landing on the same edge as a clear can all be driven directly. Status pins and control data are drawn from a seeded random source and checked against bench-computed bytes. Directed sequences cover both clear policies, freezing during a read, and reset.

// File: rtl/prn_status_pkg.sv
`timescale 1ns/1ps
package prn_status_pkg;
  localparam int STAT_OFS = 1;
  localparam int CTRL_OFS = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic setTo;    // timeout detected this cycle
    logic clrTo;    // clear request for timeout flag
    logic ctrlWr;   // control register write
    logic rdStart;  // first cycle of a read
  } strobe_t;
endpackage

// File: rtl/prn_status_ctrl.sv
`timescale 1ns/1ps
module prn_status_ctrl
  import prn_status_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int CLK_HZ     = 200_000_000,
  parameter int TIMEOUT_US = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              wrBit0,
  input  logic              toModeSel,
  input  logic              eppEn,
  input  logic              eppStrobe,
  input  logic              eppWait,
  output strobe_t           strb
);
  localparam int TO_CYCLES = (CLK_HZ / 1_000_000) * TIMEOUT_US;
  localparam int CNT_W     = $clog2(TO_CYCLES + 1);

  logic             rdPrev;
  logic             rdWasStat;
  logic [CNT_W-1:0] toCnt;
  logic             isStat, isCtrl, rdEnd, cntActive;

  assign isStat    = (regAddr == ADDR_W'(STAT_OFS));
  assign isCtrl    = (regAddr == ADDR_W'(CTRL_OFS));
  assign cntActive = eppEn && eppStrobe && !eppWait;
  assign rdEnd     = rdPrev && !rdStb && rdWasStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev    <= 1'b0;
      rdWasStat <= 1'b0;
      toCnt     <= '0;
    end else begin
      rdPrev <= rdStb;
      if (rdStb && !rdPrev) rdWasStat <= isStat;
      if (!cntActive)                          toCnt <= '0;
      else if (toCnt != CNT_W'(TO_CYCLES))     toCnt <= toCnt + 1'b1;
    end
  end

  always_comb begin
    strb.rdStart = rdStb && !rdPrev;
    strb.ctrlWr  = wrStb && isCtrl;
    strb.setTo   = cntActive && (toCnt == CNT_W'(TO_CYCLES - 1));
    strb.clrTo   = toModeSel ? rdEnd : (wrStb && isStat && wrBit0);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    toCnt <= CNT_W'(TO_CYCLES)); // R5
  AST_NO_SET_OFF_EPP: assert property (@(posedge clk) disable iff (!rstN)
    !eppEn |-> !strb.setTo); // R5
  AST_SET_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.setTo |=> !strb.setTo); // R5
  AST_RDCLR_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (toModeSel && strb.clrTo) |-> ($fell(rdStb))); // R7
endmodule

// File: rtl/prn_status_dpath.sv
`timescale 1ns/1ps
module prn_status_dpath
  import prn_status_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdStb,
  input  logic [5:0]        wrCtrlBits,
  input  strobe_t           strb,
  input  logic              errN,
  input  logic              sel,
  input  logic              paperEnd,
  input  logic              ackN,
  input  logic              busy,
  output logic [7:0]        rdData
);
  localparam int PIN_N = 5;

  logic [PIN_N-1:0] syncA, syncB;
  logic             toFlag;
  logic [5:0]       ctrlReg;
  logic [7:0]       liveByte, heldByte;

  // two-stage synchroniser, order {busy, ackN, paperEnd, sel, errN}
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= {busy, ackN, paperEnd, sel, errN};
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toFlag  <= 1'b0;
      ctrlReg <= '0;
    end else begin
      if (strb.setTo)      toFlag <= 1'b1;
      else if (strb.clrTo) toFlag <= 1'b0;
      if (strb.ctrlWr)     ctrlReg <= wrCtrlBits;
    end
  end

  always_comb begin
    liveByte = 8'h00;
    if (regAddr == ADDR_W'(STAT_OFS))
      liveByte = {~syncB[4], syncB[3], syncB[2], syncB[1], syncB[0], 2'b00, toFlag};
    else if (regAddr == ADDR_W'(CTRL_OFS))
      liveByte = {2'b00, ctrlReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN)             heldByte <= 8'h00;
    else if (strb.rdStart) heldByte <= liveByte;
  end

  assign rdData = !rdStb ? 8'h00 : (strb.rdStart ? liveByte : heldByte);

  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && $past(rdStb)) |-> $stable(rdData)); // R4
  AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strb.setTo |=> toFlag); // R5 R8
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrTo && !strb.setTo) |=> !toFlag); // R6
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> $past(strb.setTo)); // R5
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdStb |-> (rdData == 8'h00)); // R1
endmodule

// File: rtl/prn_status_regs.sv
`timescale 1ns/1ps
module prn_status_regs
  import prn_status_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int CLK_HZ     = 200_000_000,
  parameter int TIMEOUT_US = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              errN,
  input  logic              sel,
  input  logic              paperEnd,
  input  logic              ackN,
  input  logic              busy,
  input  logic              toModeSel,
  input  logic              eppEn,
  input  logic              eppStrobe,
  input  logic              eppWait
);
  strobe_t    strb;
  logic [1:0] unusedHiBits;
  assign unusedHiBits = wrData[7:6];

  prn_status_ctrl #(
    .ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .rdStb(rdStb),
    .wrStb(wrStb), .wrBit0(wrData[0]), .toModeSel(toModeSel),
    .eppEn(eppEn), .eppStrobe(eppStrobe), .eppWait(eppWait), .strb(strb)
  );

  prn_status_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .rdStb(rdStb),
    .wrCtrlBits(wrData[5:0]), .strb(strb),
    .errN(errN), .sel(sel), .paperEnd(paperEnd), .ackN(ackN), .busy(busy),
    .rdData(rdData)
  );
endmodule

// File: tb/prn_status_regs_bench.sv
`timescale 1ns/1ps
module prn_status_regs_bench;
  localparam int ADDR_W = 3;
  localparam int CLK_HZ = 2_000_000;
  localparam int TUS    = 10;
  localparam int TO     = (CLK_HZ / 1_000_000) * TUS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic rdStb = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic errN = 1'b1, sel = 1'b0, paperEnd = 1'b0, ackN = 1'b1, busy = 1'b0;
  logic toModeSel = 1'b0, eppEn = 1'b1, eppStrobe = 1'b0, eppWait = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  prn_status_regs #(.ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ), .TIMEOUT_US(TUS)) u_prn_status_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .rdData(rdData), .errN(errN), .sel(sel), .paperEnd(paperEnd),
    .ackN(ackN), .busy(busy), .toModeSel(toModeSel), .eppEn(eppEn),
    .eppStrobe(eppStrobe), .eppWait(eppWait)
  );

  function automatic logic [7:0] expStat(logic flag);
    return {~busy, ackN, paperEnd, sel, errN, 2'b00, flag};
  endfunction

  function automatic logic [7:0] expCtrl(logic [7:0] d);
    return {2'b00, d[5:0]};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic readReg(int a, output logic [7:0] v);
    regAddr = ADDR_W'(a);
    rdStb = 1'b1;
    tick(1);
    v = rdData;
    tick(1);
    rdStb = 1'b0;
    tick(1);
  endtask

  task automatic writeReg(int a, logic [7:0] d);
    regAddr = ADDR_W'(a);
    wrData = d;
    wrStb = 1'b1;
    tick(1);
    wrStb = 1'b0;
    tick(1);
  endtask

  task automatic eppRun(int n);
    eppStrobe = 1'b1;
    tick(n);
    eppStrobe = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v0, d;
    void'($urandom(32'h5eed1234));
    tick(4);
    rstN = 1'b1;
    tick(4);

    // reset state
    chk("R1 idle rdData", rdData, 8'h00);
    readReg(2, v); chk("R10 ctrl after reset", v, 8'h00);
    readReg(1, v); chk("R10 status after reset", v, expStat(1'b0));
    chk("R3 bits 2:1", {6'b0, v[2:1]}, 8'h00);
    readReg(0, v); chk("R1 offset 0", v, 8'h00);
    readReg(3, v); chk("R1 offset 3", v, 8'h00);

    // random status pins and control data
    for (int i = 0; i < 40; i++) begin
      {busy, ackN, paperEnd, sel, errN} = 5'($urandom);
      tick(3);
      readReg(1, v); chk("R2 status pins", v, expStat(1'b0));
      chk("R3 bits 2:1 random", {6'b0, v[2:1]}, 8'h00);
      d = 8'($urandom);
      writeReg(2, d);
      readReg(2, v); chk("R9 ctrl readback", v, expCtrl(d));
      readReg(5 + (i % 3), v); chk("R1 unmapped offset", v, 8'h00);
    end

    // R4: read value frozen during the cycle
    {busy, ackN, paperEnd, sel, errN} = 5'b01010;
    tick(3);
    regAddr = 1; rdStb = 1'b1;
    tick(1);
    v0 = rdData;
    chk("R4 first sample", v0, expStat(1'b0));
    {busy, ackN, paperEnd, sel, errN} = 5'b10101;
    eppStrobe = 1'b1;
    tick(TO + 2);
    eppStrobe = 1'b0;
    chk("R4 held during read", rdData, v0);
    rdStb = 1'b0;
    tick(2);
    readReg(1, v); chk("R4 new value next read", v, expStat(1'b1));
    writeReg(1, 8'h01);

    // R5 boundary
    eppRun(TO - 1);
    readReg(1, v); chk("R5 one short no flag", {7'b0, v[0]}, 8'h00);
    eppRun(TO);
    readReg(1, v); chk("R5 exact limit sets flag", {7'b0, v[0]}, 8'h01);
    writeReg(1, 8'h01);
    eppStrobe = 1'b1; tick(TO - 3); eppWait = 1'b1; tick(1); eppWait = 1'b0;
    tick(TO - 3); eppStrobe = 1'b0; tick(1);
    readReg(1, v); chk("R5 wait restarts count", {7'b0, v[0]}, 8'h00);
    eppEn = 1'b0;
    eppRun(TO + 5);
    readReg(1, v); chk("R5 no flag outside EPP", {7'b0, v[0]}, 8'h00);
    eppEn = 1'b1;

    // R6: write-one-to-clear mode
    toModeSel = 1'b0;
    eppRun(TO);
    readReg(1, v); chk("R6 set", {7'b0, v[0]}, 8'h01);
    readReg(1, v); chk("R6 read does not clear", {7'b0, v[0]}, 8'h01);
    writeReg(1, 8'hFE);
    readReg(1, v); chk("R6 write zero no effect", {7'b0, v[0]}, 8'h01);
    writeReg(1, 8'h01);
    readReg(1, v); chk("R6 write one clears", {7'b0, v[0]}, 8'h00);

    // R8: timeout and write-clear on the same edge
    eppStrobe = 1'b1;
    tick(TO - 1);
    regAddr = 1; wrData = 8'h01; wrStb = 1'b1;
    tick(1);
    wrStb = 1'b0; eppStrobe = 1'b0;
    tick(1);
    readReg(1, v); chk("R8 set wins", {7'b0, v[0]}, 8'h01);

    // R7: clear at end of status read
    toModeSel = 1'b1;
    writeReg(1, 8'h01);
    readReg(1, v); chk("R7 write ignored, read sees flag", {7'b0, v[0]}, 8'h01);
    readReg(1, v); chk("R7 cleared after read", {7'b0, v[0]}, 8'h00);
    eppRun(TO);
    readReg(2, v); chk("R7 ctrl read keeps ctrl", v, expCtrl(d));
    readReg(1, v); chk("R7 ctrl read did not clear", {7'b0, v[0]}, 8'h01);

    // R10: reset clears flag and control
    writeReg(2, 8'hFF);
    eppRun(TO);
    rstN = 1'b0; tick(2); rstN = 1'b1; tick(3);
    readReg(2, v); chk("R10 ctrl cleared", v, 8'h00);
    readReg(1, v); chk("R10 flag cleared", {7'b0, v[0]}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule